// File: doc/BRIEF.md
# Serial DAC word loader

The block assembles a 16-bit control word for an external parallel DAC from a single serial data line. The host presents one bit on the data line and pulses a write strobe. Each rising edge of that strobe moves the chain by one stage. Once a word is complete, the low twelve stages drive the DAC code. The next three stages give a 3-bit routing select that steers the DAC output to one of eight analog destinations. The top stage is returned to the host, so it can write a pattern and read it back to test the chain.

The DAC output has no useful meaning while the word is still shifting in, so the block holds every analog multiplexer enable low during a load. Any strobe edge drops all enables and marks the load unfinished. After the sixteenth edge of a group, the host writes a separate enable register to switch on one multiplexer, or none. Enable writes that arrive before the load is finished have no effect.

Top module: `dac_word_loader`

## Requirements
- R1: While rst_ni is low, the shift chain, the strobe-edge detector, the load counter and every multiplexer enable are cleared, so dac_code_o, route_sel_o, readback_o and mux_en_o are all 0.
- R2: The chain moves by exactly one stage on each clock cycle where wr_strobe_i is high and was low in the previous cycle. Bit 0 takes ser_data_i. A strobe held high over several cycles moves it only once. With no rising strobe edge, the chain outputs hold.
- R3: Bits are sent most significant first. After 16 strobe edges, dac_code_o equals word bits 11:0.
- R4: After 16 strobe edges, route_sel_o equals word bits 14:12.
- R5: readback_o always shows the top stage (bit 15) of the chain, which is the bit sent 16 strobe edges earlier. A 17th edge shifts it out.
- R6: The cycle after any strobe edge, mux_en_o is all zero.
- R7: A load is complete only after the 16th strobe edge of a group, counted from reset. Groups restart after every 16 edges. While a load is incomplete, enable writes (en_wr_i) leave mux_en_o at zero.
- R8: With a complete load, an enable write with en_on_i=1 sets mux_en_o to the one-hot value 1<<en_idx_i. An enable write with en_on_i=0 sets it to zero. At most one bit of mux_en_o is ever high.
- R9: If a strobe edge and an enable write occur in the same cycle, the strobe wins: the enables clear, and the load becomes incomplete again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_strobe_i | input | 1 | Host write strobe; each rising edge shifts one bit |
| ser_data_i | input | 1 | Serial data bit |
| en_wr_i | input | 1 | Enable-register write |
| en_on_i | input | 1 | 1 selects a multiplexer, 0 turns all off |
| en_idx_i | input | 2 | Index of the multiplexer to enable |
| dac_code_o | output | 12 | Conversion code to the DAC |
| route_sel_o | output | 3 | Routing select for the analog multiplexers |
| readback_o | output | 1 | Top stage of the shift chain |
| mux_en_o | output | 4 | One-hot multiplexer enables |

## Verification
The bench holds the strobe high over several cycles to catch a design that shifts on the level instead of on the edge; such a design would move the code several stages. It tries enable writes after partial loads of random length and right after a 17th edge, where a design that forgot the group count would switch on a multiplexer during a load. It also drives a strobe edge and an enable write in the same cycle, where a design that gave the enable priority would route a meaningless DAC output. Readback is checked after extra shifts to expose a chain wired in the wrong order.

// File: rtl/dac_word_loader_pkg.sv
package dac_word_loader_pkg;
  parameter int unsigned WORD_W  = 16;
  parameter int unsigned CODE_W  = 12;
  parameter int unsigned SEL_W   = 3;
  parameter int unsigned NUM_MUX = 4;
  localparam int unsigned CNT_W  = $clog2(WORD_W);
  localparam int unsigned IDX_W  = $clog2(NUM_MUX);
endpackage

// File: rtl/dac_strobe_edge.sv
module dac_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic fire_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= strobe_i;
  end

  assign fire_o = strobe_i & ~prev_q;
endmodule

// File: rtl/dac_shift_chain.sv
module dac_shift_chain #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              data_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (fire_i) sr_q <= {sr_q[WORD_W-2:0], data_i};
  end

  assign word_o = sr_q;
endmodule

// File: rtl/dac_load_track.sv
module dac_load_track #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (fire_i) begin
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      done_q <= (cnt_q == LAST);
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/dac_mux_enable.sv
module dac_mux_enable #(
  parameter int unsigned NUM_MUX = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_MUX)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               done_i,
  input  logic               wr_i,
  input  logic               on_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [NUM_MUX-1:0] en_o
);
  logic [NUM_MUX-1:0] en_q;
  logic [NUM_MUX-1:0] dec;

  for (genvar g = 0; g < NUM_MUX; g++) begin : g_dec
    assign dec[g] = on_i && (idx_i == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              en_q <= '0;
    else if (fire_i)          en_q <= '0;  // loading: nothing routed
    else if (wr_i && done_i)  en_q <= dec;
  end

  assign en_o = en_q;
endmodule

// File: rtl/dac_word_loader.sv
module dac_word_loader
  import dac_word_loader_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_strobe_i,
  input  logic               ser_data_i,
  input  logic               en_wr_i,
  input  logic               en_on_i,
  input  logic [IDX_W-1:0]   en_idx_i,
  output logic [CODE_W-1:0]  dac_code_o,
  output logic [SEL_W-1:0]   route_sel_o,
  output logic               readback_o,
  output logic [NUM_MUX-1:0] mux_en_o
);
  logic              fire;
  logic              load_done;
  logic [WORD_W-1:0] word;

  dac_strobe_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(wr_strobe_i), .fire_o(fire)
  );

  dac_shift_chain #(.WORD_W(WORD_W)) u_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .data_i(ser_data_i),
    .word_o(word)
  );

  dac_load_track #(.WORD_W(WORD_W)) u_track (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .done_o(load_done)
  );

  dac_mux_enable #(.NUM_MUX(NUM_MUX)) u_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .done_i(load_done),
    .wr_i(en_wr_i), .on_i(en_on_i), .idx_i(en_idx_i), .en_o(mux_en_o)
  );

  assign dac_code_o  = word[CODE_W-1:0];
  assign route_sel_o = word[CODE_W+SEL_W-1:CODE_W];
  assign readback_o  = word[WORD_W-1];
endmodule

// File: rtl/dac_word_loader_chk.sv
module dac_word_loader_chk
  import dac_word_loader_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_strobe_i,
  input logic               ser_data_i,
  input logic               en_wr_i,
  input logic [CODE_W-1:0]  dac_code_o,
  input logic [SEL_W-1:0]   route_sel_o,
  input logic               readback_o,
  input logic [NUM_MUX-1:0] mux_en_o,
  input logic               load_done
);
  logic strobe_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_d <= 1'b0;
    else         strobe_d <= wr_strobe_i;
  end
  wire edge_seen = wr_strobe_i && !strobe_d;

  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (mux_en_o == '0 && dac_code_o == '0 && readback_o == 1'b0);
    end
  end

  a_r2_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_seen |=> (dac_code_o[0] == $past(ser_data_i)) &&
                  (dac_code_o[CODE_W-1:1] == $past(dac_code_o[CODE_W-2:0])));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_seen |=> $stable({readback_o, route_sel_o, dac_code_o}));

  a_r5_top_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_seen |=> readback_o == $past(route_sel_o[SEL_W-1]));

  a_r6_strobe_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_seen |=> mux_en_o == '0);

  a_r7_ignored_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && !load_done) |=> mux_en_o == '0);

  a_r8_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mux_en_o));
endmodule

bind dac_word_loader dac_word_loader_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_strobe_i(wr_strobe_i),
  .ser_data_i(ser_data_i), .en_wr_i(en_wr_i), .dac_code_o(dac_code_o),
  .route_sel_o(route_sel_o), .readback_o(readback_o), .mux_en_o(mux_en_o),
  .load_done(load_done)
);

// File: tb/dac_word_loader_test.sv
module dac_word_loader_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_strobe_i = 1'b0;
  logic       ser_data_i = 1'b0;
  logic       en_wr_i = 1'b0;
  logic       en_on_i = 1'b0;
  logic [1:0] en_idx_i = '0;
  logic [11:0] dac_code_o;
  logic [2:0]  route_sel_o;
  logic        readback_o;
  logic [3:0]  mux_en_o;

  int checks = 0;
  int fails  = 0;

  logic [15:0] sr_m = '0;
  int          cnt_m = 0;
  bit          done_m = 0;
  logic [3:0]  en_m = '0;

  always #5 clk_i = ~clk_i;

  dac_word_loader uut (.*);

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model_fire(bit b);
    sr_m = {sr_m[14:0], b};
    en_m = '0;
    done_m = (cnt_m == 15);
    cnt_m = (cnt_m + 1) % 16;
  endfunction

  task automatic check_all(string req);
    check({req, " code"}, 32'(dac_code_o), 32'(sr_m[11:0]));
    check({req, " sel"}, 32'(route_sel_o), 32'(sr_m[14:12]));
    check({req, " readback"}, 32'(readback_o), 32'(sr_m[15]));
    check({req, " mux_en"}, 32'(mux_en_o), 32'(en_m));
  endtask

  task automatic shift_bit(bit b);
    @(negedge clk_i);
    ser_data_i = b;
    wr_strobe_i = 1'b1;
    @(negedge clk_i);
    wr_strobe_i = 1'b0;
    model_fire(b);
  endtask

  task automatic load_word(logic [15:0] w);
    for (int i = 15; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic en_write(bit on, logic [1:0] idx);
    @(negedge clk_i);
    en_wr_i = 1'b1; en_on_i = on; en_idx_i = idx;
    @(negedge clk_i);
    en_wr_i = 1'b0;
    if (done_m) en_m = on ? (4'b1 << idx) : 4'b0;
  endtask

  initial begin
    logic [15:0] w;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 code", 32'(dac_code_o), 0);
    check("R1 readback", 32'(readback_o), 0);
    check("R1 mux_en", 32'(mux_en_o), 0);
    rst_ni = 1'b1;

    // R7 enable write before any load
    en_write(1'b1, 2'd1);
    check("R7 no load", 32'(mux_en_o), 0);

    // R3 R4 R5 directed word
    load_word(16'hA5C3);
    check("R3 code", 32'(dac_code_o), 32'h5C3);
    check("R4 sel", 32'(route_sel_o), 32'h2);
    check("R5 readback", 32'(readback_o), 1);

    // R8 enable and disable
    en_write(1'b1, 2'd3);
    check("R8 onehot", 32'(mux_en_o), 32'h8);
    en_write(1'b0, 2'd3);
    check("R8 off", 32'(mux_en_o), 0);
    en_write(1'b1, 2'd0);
    check("R8 idx0", 32'(mux_en_o), 32'h1);

    // R2 strobe held high shifts once; R6 clears enables
    @(negedge clk_i);
    ser_data_i = 1'b0;
    wr_strobe_i = 1'b1;
    model_fire(1'b0);
    repeat (4) @(negedge clk_i);
    wr_strobe_i = 1'b0;
    check_all("R2 held");
    check("R6 cleared", 32'(mux_en_o), 0);

    // R5 17th edge shifted top stage out; R7 load incomplete now
    check("R5 shifted out", 32'(readback_o), 32'(16'hA5C3 >> 14) & 1);
    en_write(1'b1, 2'd2);
    check("R7 after 17th", 32'(mux_en_o), 0);
    for (int i = 0; i < 15; i++) shift_bit(1'(i));
    en_write(1'b1, 2'd2);
    check("R7 group done", 32'(mux_en_o), 32'h4);

    // R9 strobe and enable write in same cycle
    @(negedge clk_i);
    ser_data_i = 1'b1; wr_strobe_i = 1'b1;
    en_wr_i = 1'b1; en_on_i = 1'b1; en_idx_i = 2'd1;
    @(negedge clk_i);
    wr_strobe_i = 1'b0; en_wr_i = 1'b0;
    model_fire(1'b1);
    check("R9 strobe wins", 32'(mux_en_o), 0);
    check_all("R9");
    for (int i = 0; i < 15; i++) shift_bit(1'b0);

    // random words and partial loads
    for (int n = 0; n < 40; n++) begin
      w = 16'($urandom);
      load_word(w);
      check("R3 rand code", 32'(dac_code_o), 32'(w[11:0]));
      check("R4 rand sel", 32'(route_sel_o), 32'(w[14:12]));
      check("R5 rand readback", 32'(readback_o), 32'(w[15]));
      en_write(1'($urandom), 2'($urandom));
      check_all("R8 rand");
      begin
        int k = 1 + ($urandom % 15);
        for (int i = 0; i < k; i++) shift_bit(1'($urandom));
        check("R6 rand clear", 32'(mux_en_o), 0);
        en_write(1'b1, 2'($urandom));
        check("R7 partial", 32'(mux_en_o), 0);
        check_all("R2 partial");
        for (int i = k; i < 16; i++) shift_bit(1'($urandom));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule